// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM out of power-up. A single start pulse launches a fixed script of memory commands on a command port that uses a valid/ready handshake. The script begins with a NOP and a long settling pause. It then precharges every bank and writes the three extended mode registers. Next comes a DLL reset phase with a mode-register write, a precharge and two refreshes. The DLL reset is then released with a second mode-register write. Output-driver calibration is entered and left, and the script finishes with the normal-mode command and one dummy write. The last step copies the refresh-rate value into a refresh-timer output.

Extended mode-register writes choose their target register through the bank-address bits. Where those bits sit in the address depends on the memory geometry, so the block works out the bank bit offset itself when it starts. The inputs are the column field, the row field, the bus width, the interleave setting and the controller version. The settling pause is counted in clock cycles, and its length comes from two parameters: clock frequency and pause length.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is asserted and until a start pulse, busy, done, cmd_valid and refresh_load are 0 and refresh_rate_q is 0.
- R2: In the cycle after start is sampled high in the idle state, busy is 1 and a NOP (cmd_code 1) is offered with cmd_valid.
- R3: The second NOP is accepted no sooner than CLK_FREQ_MHZ*PWRUP_WAIT_US+1 cycles after the first. With cmd_ready held high the gap is exactly that.
- R4: The accepted commands are these 15, in this order, and no others. cmd_code encodes NORMAL=0, NOP=1, PRECHARGE_ALL=2, MODE_SET=3, REFRESH=4, EXT_MODE_SET=5, DUMMY_WRITE=6. The order is NOP, NOP, PRECHARGE_ALL, EXT_MODE_SET x3, MODE_SET, PRECHARGE_ALL, REFRESH, REFRESH, MODE_SET, EXT_MODE_SET x2, NORMAL, DUMMY_WRITE.
- R5: The bank offset is the column field plus 9, plus the bus term: 1 when cfg_wide_bus is 0, 2 when it is 1. Under sequential decoding the row field plus 11 is also added.
- R6: Decoding is interleaved, so the row term is dropped, only when cfg_interleave is 1 and ctrl_version is at least 0x140. Otherwise decoding is sequential.
- R7: The three extended writes after the precharge carry bank selects 2, 3 and 1, in that order. The two calibration writes carry bank select 1. Each extended write's cmd_addr is its bank select shifted left by the bank offset. Every other command has cmd_addr 0.
- R8: cmd_dll_reset is 1 on exactly the first MODE_SET, the following PRECHARGE_ALL and both REFRESH commands. cmd_ocd_default is 1 only on the first of the two final EXT_MODE_SET commands.
- R9: The sequence advances only on a cycle with cmd_valid and cmd_ready both high. While the port stalls, the offered command and address stay unchanged.
- R10: After the dummy write is accepted, refresh_load pulses for exactly one cycle and refresh_rate_q takes refresh_rate_in.
- R11: busy is high only while the script runs. done rises after the refresh load and then stays high until reset. A start pulse while busy or done has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse |
| cfg_col_bits | input | 2 | Column-count field |
| cfg_row_bits | input | 2 | Row-count field |
| cfg_interleave | input | 1 | Bank interleave request |
| cfg_wide_bus | input | 1 | 1 = wide data bus |
| ctrl_version | input | VER_W | Controller version |
| refresh_rate_in | input | RTR_W | Refresh rate to load |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted |
| cmd_code | output | 3 | Command code |
| cmd_addr | output | ADDR_W | Command address |
| cmd_dll_reset | output | 1 | DLL reset setting for this command |
| cmd_ocd_default | output | 1 | Calibration-default setting for this command |
| refresh_rate_q | output | RTR_W | Refresh timer value |
| refresh_load | output | 1 | One-cycle load strobe |
| busy | output | 1 | Script running |
| done | output | 1 | Script complete |

## Verification
The bench builds the block with CLK_FREQ_MHZ=2 and PWRUP_WAIT_US=3. That shrinks the settling pause to 6 cycles, so the exact NOP-to-NOP gap can be checked and a whole script finishes in a few dozen cycles. This makes it cheap to rerun the script under five geometry settings. The settings include version 0x13F and 0x200 with the interleave bit set, plus the smallest and largest offsets. Two of the runs stall the command port on two cycles out of three.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL        = 3'd0,
    CMD_NOP           = 3'd1,
    CMD_PRECHARGE_ALL = 3'd2,
    CMD_MODE_SET      = 3'd3,
    CMD_REFRESH       = 3'd4,
    CMD_EXT_MODE_SET  = 3'd5,
    CMD_DUMMY_WRITE   = 3'd6
  } cmd_e;

  typedef enum logic [1:0] {
    ACT_CMD,
    ACT_WAIT,
    ACT_LOAD
  } act_e;

  typedef struct packed {
    act_e       act;
    cmd_e       code;
    logic [1:0] bank_sel;
    logic       dll_rst;
    logic       ocd_dflt;
  } step_t;

  localparam int STEP_W    = 5;
  localparam int LAST_STEP = 16;

  // Script: one entry per step, executed in index order.
  function automatic step_t step_lookup(input logic [STEP_W-1:0] idx);
    step_t s;
    s = '{act: ACT_CMD, code: CMD_NOP, bank_sel: 2'd0, dll_rst: 1'b0, ocd_dflt: 1'b0};
    case (idx)
      5'd0:  s.code = CMD_NOP;
      5'd1:  s.act  = ACT_WAIT;
      5'd2:  s.code = CMD_NOP;
      5'd3:  s.code = CMD_PRECHARGE_ALL;
      5'd4:  begin s.code = CMD_EXT_MODE_SET; s.bank_sel = 2'd2; end
      5'd5:  begin s.code = CMD_EXT_MODE_SET; s.bank_sel = 2'd3; end
      5'd6:  begin s.code = CMD_EXT_MODE_SET; s.bank_sel = 2'd1; end
      5'd7:  begin s.code = CMD_MODE_SET;      s.dll_rst = 1'b1; end
      5'd8:  begin s.code = CMD_PRECHARGE_ALL; s.dll_rst = 1'b1; end
      5'd9:  begin s.code = CMD_REFRESH;       s.dll_rst = 1'b1; end
      5'd10: begin s.code = CMD_REFRESH;       s.dll_rst = 1'b1; end
      5'd11: s.code = CMD_MODE_SET;
      5'd12: begin s.code = CMD_EXT_MODE_SET; s.bank_sel = 2'd1; s.ocd_dflt = 1'b1; end
      5'd13: begin s.code = CMD_EXT_MODE_SET; s.bank_sel = 2'd1; end
      5'd14: s.code = CMD_NORMAL;
      5'd15: s.code = CMD_DUMMY_WRITE;
      default: s.act = ACT_LOAD;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ddr2_bank_offset.sv
module ddr2_bank_offset #(
  parameter int COL_W              = 2,
  parameter int ROW_W              = 2,
  parameter int VER_W              = 16,
  parameter int OFF_W              = 5,
  parameter int INTERLEAVE_MIN_VER = 16'h0140
) (
  input  logic [COL_W-1:0] col_bits,
  input  logic [ROW_W-1:0] row_bits,
  input  logic             interleave,
  input  logic             wide_bus,
  input  logic [VER_W-1:0] version,
  output logic [OFF_W-1:0] bank_off
);

  localparam logic [OFF_W-1:0] COL_BASE = OFF_W'(9);
  localparam logic [OFF_W-1:0] ROW_BASE = OFF_W'(11);
  localparam logic [VER_W-1:0] MIN_VER  = VER_W'(INTERLEAVE_MIN_VER);

  logic             seq_decode;
  logic [OFF_W-1:0] row_term;
  logic [OFF_W-1:0] bus_term;

  always_comb begin
    seq_decode = !(interleave && (version >= MIN_VER));
    row_term   = seq_decode ? (OFF_W'(row_bits) + ROW_BASE) : '0;
    bus_term   = wide_bus ? OFF_W'(2) : OFF_W'(1);
    bank_off   = OFF_W'(col_bits) + COL_BASE + row_term + bus_term;
  end

endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en  = run || (cnt_q != '0);
    cnt_d   = run ? (cnt_q + 1'b1) : '0;
    expired = run && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_FREQ_MHZ       = 200,
  parameter int PWRUP_WAIT_US      = 200,
  parameter int ADDR_W             = 32,
  parameter int RTR_W              = 12,
  parameter int VER_W              = 16,
  parameter int INTERLEAVE_MIN_VER = 16'h0140
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_col_bits,
  input  logic [1:0]        cfg_row_bits,
  input  logic              cfg_interleave,
  input  logic              cfg_wide_bus,
  input  logic [VER_W-1:0]  ctrl_version,
  input  logic [RTR_W-1:0]  refresh_rate_in,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [2:0]        cmd_code,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              cmd_dll_reset,
  output logic              cmd_ocd_default,
  output logic [RTR_W-1:0]  refresh_rate_q,
  output logic              refresh_load,
  output logic              busy,
  output logic              done
);

  localparam int WAIT_CYCLES = CLK_FREQ_MHZ * PWRUP_WAIT_US;
  localparam int OFF_W       = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_e;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  state_e            state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [OFF_W-1:0]  off_q, off_calc;
  logic              off_en, step_en;
  logic              rtr_en;
  step_t             cur;
  logic              running, tmr_run, tmr_expired, advance;

  ddr2_bank_offset #(
    .COL_W(2), .ROW_W(2), .VER_W(VER_W), .OFF_W(OFF_W),
    .INTERLEAVE_MIN_VER(INTERLEAVE_MIN_VER)
  ) u_offset (
    .col_bits  (cfg_col_bits),
    .row_bits  (cfg_row_bits),
    .interleave(cfg_interleave),
    .wide_bus  (cfg_wide_bus),
    .version   (ctrl_version),
    .bank_off  (off_calc)
  );

  ddr2_wait_timer #(.CYCLES(WAIT_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (tmr_run),
    .expired(tmr_expired)
  );

  always_comb begin
    cur          = step_lookup(step_q);
    running      = (state_q == ST_RUN);
    cmd_valid    = running && (cur.act == ACT_CMD);
    tmr_run      = running && (cur.act == ACT_WAIT);
    refresh_load = running && (cur.act == ACT_LOAD);
    advance      = (cmd_valid && cmd_ready) || (tmr_run && tmr_expired);

    state_d = state_q;
    step_d  = step_q;
    off_en  = 1'b0;
    step_en = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_RUN;
        step_d  = '0;
        step_en = 1'b1;
        off_en  = 1'b1;
      end
      ST_RUN: begin
        if (refresh_load) begin
          state_d = ST_DONE;
        end else if (advance) begin
          step_d  = step_q + 1'b1;
          step_en = 1'b1;
        end
      end
      default: state_d = state_q;
    endcase
    rtr_en = refresh_load;

    cmd_code        = cur.code;
    cmd_addr        = ADDR_W'(cur.bank_sel) << off_q;
    cmd_dll_reset   = cmd_valid && cur.dll_rst;
    cmd_ocd_default = cmd_valid && cur.ocd_dflt;
    busy            = running;
    done            = (state_q == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   step_q <= '0;
    else if (step_en) step_q <= step_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  off_q <= '0;
    else if (off_en) off_q <= off_calc;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  refresh_rate_q <= '0;
    else if (rtr_en) refresh_rate_q <= refresh_rate_in;
  end

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_code,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ocd_default,
  input logic              refresh_load,
  input logic              busy,
  input logic              done
);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr)));

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  p_busy_done_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  p_valid_needs_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy);

  p_load_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_load |=> (done && !refresh_load));

  p_ocd_on_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ocd_default |-> (cmd_code == 3'd5));

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cmd_valid      (cmd_valid),
  .cmd_ready      (cmd_ready),
  .cmd_code       (cmd_code),
  .cmd_addr       (cmd_addr),
  .cmd_ocd_default(cmd_ocd_default),
  .refresh_load   (refresh_load),
  .busy           (busy),
  .done           (done)
);

// File: tb/ddr2_init_seq_tb_top.sv
`timescale 1ns/1ps
module ddr2_init_seq_tb_top;

  localparam int FREQ   = 2;
  localparam int WAIT_US = 3;
  localparam int W      = FREQ * WAIT_US;
  localparam int ADDR_W = 32;
  localparam int RTR_W  = 12;
  localparam int NCMD   = 15;
  localparam int NCFG   = 5;

  // {code[6:4], bank_sel[3:2], dll[1], ocd[0]}
  localparam logic [6:0] EXP_SEQ [NCMD] = '{
    7'b001_00_0_0, 7'b001_00_0_0, 7'b010_00_0_0,
    7'b101_10_0_0, 7'b101_11_0_0, 7'b101_01_0_0,
    7'b011_00_1_0, 7'b010_00_1_0, 7'b100_00_1_0, 7'b100_00_1_0,
    7'b011_00_0_0, 7'b101_01_0_1, 7'b101_01_0_0,
    7'b000_00_0_0, 7'b110_00_0_0
  };

  // {col[26:25], row[24:23], interleave[22], wide[21], version[20:5], offset[4:0]}
  localparam logic [26:0] CFG [NCFG] = '{
    {2'd0, 2'd0, 1'b0, 1'b0, 16'h0140, 5'd21},
    {2'd3, 2'd3, 1'b0, 1'b1, 16'h0140, 5'd28},
    {2'd2, 2'd1, 1'b1, 1'b0, 16'h0140, 5'd12},
    {2'd1, 2'd2, 1'b1, 1'b1, 16'h013F, 5'd25},
    {2'd1, 2'd1, 1'b1, 1'b1, 16'h0200, 5'd12}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        cfg_col_bits = '0;
  logic [1:0]        cfg_row_bits = '0;
  logic              cfg_interleave = 1'b0;
  logic              cfg_wide_bus = 1'b0;
  logic [15:0]       ctrl_version = '0;
  logic [RTR_W-1:0]  refresh_rate_in = '0;
  logic              cmd_ready = 1'b1;
  logic              cmd_valid;
  logic [2:0]        cmd_code;
  logic [ADDR_W-1:0] cmd_addr;
  logic              cmd_dll_reset, cmd_ocd_default;
  logic [RTR_W-1:0]  refresh_rate_q;
  logic              refresh_load, busy, done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit stall = 1'b0;

  always #2.5 clk = ~clk;

  ddr2_init_seq #(
    .CLK_FREQ_MHZ(FREQ), .PWRUP_WAIT_US(WAIT_US), .ADDR_W(ADDR_W), .RTR_W(RTR_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_col_bits(cfg_col_bits), .cfg_row_bits(cfg_row_bits),
    .cfg_interleave(cfg_interleave), .cfg_wide_bus(cfg_wide_bus),
    .ctrl_version(ctrl_version), .refresh_rate_in(refresh_rate_in),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_dll_reset(cmd_dll_reset),
    .cmd_ocd_default(cmd_ocd_default), .refresh_rate_q(refresh_rate_q),
    .refresh_load(refresh_load), .busy(busy), .done(done)
  );

  // Log of accepted commands
  logic [6:0]        log_cmd  [32];
  logic [ADDR_W-1:0] log_addr [32];
  int                log_cyc  [32];
  int                n_log = 0;
  int                n_load = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      n_log  <= 0;
      n_load <= 0;
    end else begin
      if (cmd_valid && cmd_ready && n_log < 32) begin
        log_cmd[n_log]  <= {cmd_code, 2'b00, cmd_dll_reset, cmd_ocd_default};
        log_addr[n_log] <= cmd_addr;
        log_cyc[n_log]  <= cyc;
        n_log           <= n_log + 1;
      end
      if (refresh_load) n_load <= n_load + 1;
    end
  end

  // Ready pattern applied away from the active edge
  always @(negedge clk) cmd_ready <= stall ? ((cyc % 3) == 2) : 1'b1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int idx, input bit stalled);
    logic [26:0] c;
    logic [4:0]  off;
    int          waited;
    c = CFG[idx];
    off = c[4:0];
    @(negedge clk);
    stall = stalled;
    cfg_col_bits = c[26:25]; cfg_row_bits = c[24:23];
    cfg_interleave = c[22]; cfg_wide_bus = c[21]; ctrl_version = c[20:5];
    refresh_rate_in = RTR_W'(12'h100 + idx * 12'h011);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !cmd_valid && !refresh_load && refresh_rate_q == '0, "R1 reset state",
        {busy, done, cmd_valid, refresh_load}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !cmd_valid, "R1 idle before start", {busy, done, cmd_valid}, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: busy and first NOP offered one cycle later
    chk(busy && cmd_valid && cmd_code == 3'd1, "R2 first command NOP", {busy, cmd_valid, cmd_code}, 5'b11001);
    repeat (10) @(negedge clk);
    start = 1'b1;   // R11: ignored while busy
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    chk(done && !busy, "R11 done after script", {done, busy}, 2'b10);
    // R4, R7, R8: command log
    chk(n_log == NCMD, "R4 command count", n_log, NCMD);
    for (int i = 0; i < NCMD; i++) begin
      logic [ADDR_W-1:0] ea;
      ea = ADDR_W'(EXP_SEQ[i][3:2]) << off;
      chk(log_cmd[i][6:4] == EXP_SEQ[i][6:4], $sformatf("R4 code step %0d", i), log_cmd[i][6:4], EXP_SEQ[i][6:4]);
      chk(log_cmd[i][1:0] == EXP_SEQ[i][1:0], $sformatf("R8 dll/ocd step %0d", i), log_cmd[i][1:0], EXP_SEQ[i][1:0]);
      chk(log_addr[i] == ea, $sformatf("R7 R5 R6 addr step %0d cfg %0d", i, idx), log_addr[i], ea);
    end
    // R3: settling pause between the two NOPs
    if (stalled)
      chk(log_cyc[1] - log_cyc[0] >= W + 1, "R3 R9 pause under stall", log_cyc[1] - log_cyc[0], W + 1);
    else
      chk(log_cyc[1] - log_cyc[0] == W + 1, "R3 pause length", log_cyc[1] - log_cyc[0], W + 1);
    // R10: refresh load
    chk(n_load == 1, "R10 single load strobe", n_load, 1);
    chk(refresh_rate_q == refresh_rate_in, "R10 refresh value", refresh_rate_q, refresh_rate_in);
    // R11: start after done is ignored
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(done && !busy && !cmd_valid && n_log == NCMD, "R11 start ignored when done",
        {done, busy, cmd_valid}, 3'b100);
  endtask

  initial begin
    for (int k = 0; k < NCFG; k++) run_cfg(k, (k == 1) || (k == 3));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule